// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block keeps the single reservation that pairs a load-linked access with a later store-conditional. A load-linked strobe arms the reservation and records the upper bits of its physical address in a readable link-address register. A later store-conditional in word or doubleword size is allowed to write memory only while the reservation is armed. Whatever the outcome, the store-conditional disarms the reservation and hands back a 64-bit success value of 0 or 1 for the destination register. Success depends only on the reservation flag; the store's address is not compared with the recorded link address.

A store-conditional whose address is misaligned for its size raises an address-error-on-store pulse. It does not write memory, does not produce a result and does not change the reservation. An exception-return pulse disarms the reservation, so an atomic sequence that an exception handler interrupts always fails. All outputs are registered and appear one clock after the strobes are sampled.

Top module: `llsc_monitor`

## Requirements
- R1: After reset `linkBit`, `memWrEn`, `scResultValid`, `scResult`, `addrErrStore` and `linkAddr` are all zero.
- R2: A cycle with `llValid` high sets `linkBit`, which is visible one clock later.
- R3: A cycle with `llValid` high loads `linkAddr` with `llAddr` shifted right by 4. The value is visible one clock later, and it is loaded even when the reservation is cleared in the same cycle.
- R4: An aligned store-conditional while `linkBit` is 1 produces, one clock later, a one-cycle `memWrEn` pulse. It carries `memWrAddr`=`scAddr`, `memWrData`=`scData` and `memWrDouble`=`scIsDouble`, together with `scResultValid`=1 and `scResult`=1.
- R5: An aligned store-conditional while `linkBit` is 0 gives no write, with `scResultValid`=1 and `scResult`=0 one clock later.
- R6: Every aligned store-conditional clears `linkBit`, whether it succeeds or fails, unless a load-linked arrives in the same cycle.
- R7: A word store-conditional (`scIsDouble`=0) is aligned when `scAddr[1:0]`=0. A doubleword one is aligned when `scAddr[2:0]`=0. A misaligned one gives, one clock later, a one-cycle `addrErrStore` pulse, with no `memWrEn` and no `scResultValid`.
- R8: A misaligned store-conditional leaves `linkBit` unchanged.
- R9: A cycle with `eretClr` high clears `linkBit`.
- R10: When `eretClr` and `llValid` are high in the same cycle, `linkBit` ends at 0.
- R11: When a load-linked and an aligned store-conditional share a cycle, the store is judged on the flag value from before that cycle, and `linkBit` ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| llValid | input | 1 | Load-linked strobe |
| llAddr | input | 32 | Physical address of the load-linked |
| scValid | input | 1 | Store-conditional strobe |
| scIsDouble | input | 1 | 1 for a doubleword store, 0 for a word store |
| scAddr | input | 32 | Address of the store-conditional |
| scData | input | 64 | Store data |
| eretClr | input | 1 | Exception-return clear of the reservation |
| memWrEn | output | 1 | Memory write enable |
| memWrAddr | output | 32 | Memory write address |
| memWrData | output | 64 | Memory write data |
| memWrDouble | output | 1 | Memory write size, 1 for doubleword |
| scResult | output | 64 | Value for the destination register (0 or 1) |
| scResultValid | output | 1 | `scResult` is to be written back |
| addrErrStore | output | 1 | Address error on store |
| linkAddr | output | 28 | Link-address register |
| linkBit | output | 1 | Reservation flag |

## Verification
The hardest cases are the collisions: a load-linked that arrives in the same cycle as a clearing event, whether that event is an exception return or a store-conditional. The outcome there is decided only by the priority in the next-state logic. The bench drives both strobes in one cycle with the flag armed beforehand and with it disarmed, then reads the flag and the result. It also runs a sweep over every pairing of prior flag state, store size and low three address bits. That sweep reaches the misaligned-store path with the flag both armed and disarmed, which shows that the error leaves the reservation as it was.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  // Decisions taken by the control for one sampled cycle
  typedef struct packed {
    logic wrEn;        // aligned store with reservation armed
    logic resultValid; // aligned store completes
    logic resultBit;   // success value
    logic addrErr;     // misaligned store
    logic llCapture;   // load the link-address register
  } llscStrobes_t;
endpackage

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
  import llsc_pkg::*;
#(
  parameter int WORD_BYTES   = 4,
  parameter int DOUBLE_BYTES = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         llValid,
  input  logic         scValid,
  input  logic         scIsDouble,
  input  logic [$clog2(DOUBLE_BYTES)-1:0] scAddrLow,
  input  logic         eretClr,
  output llscStrobes_t strobes,
  output logic         linkBit
);
  localparam int LOW_W = $clog2(DOUBLE_BYTES);
  localparam logic [LOW_W-1:0] WORD_MASK   = LOW_W'(WORD_BYTES - 1);
  localparam logic [LOW_W-1:0] DOUBLE_MASK = LOW_W'(DOUBLE_BYTES - 1);

  logic             linkQ;
  logic             linkNext;
  logic [LOW_W-1:0] alignMask;
  logic             misaligned;
  logic             scOk;

  always_comb begin
    alignMask  = scIsDouble ? DOUBLE_MASK : WORD_MASK;
    misaligned = |(scAddrLow & alignMask);
    scOk       = scValid && !misaligned;
  end

  always_comb begin
    strobes.wrEn        = scOk && linkQ;
    strobes.resultValid = scOk;
    strobes.resultBit   = linkQ;
    strobes.addrErr     = scValid && misaligned;
    strobes.llCapture   = llValid;
  end

  // Priority: exception return, then load-linked, then completed store
  always_comb begin
    if (eretClr)      linkNext = 1'b0;
    else if (llValid) linkNext = 1'b1;
    else if (scOk)    linkNext = 1'b0;
    else              linkNext = linkQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) linkQ <= 1'b0;
    else       linkQ <= linkNext;
  end

  assign linkBit = linkQ;

  AST_LL_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    llValid && !eretClr |=> linkBit); // R2
  AST_SC_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.resultValid && !llValid |=> !linkBit); // R6
  AST_MISALIGN_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.addrErr && !llValid && !eretClr |=> $stable(linkBit)); // R8
  AST_ERET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    eretClr |=> !linkBit); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.resultValid, strobes.addrErr}) <= 1); // R7
endmodule

// File: rtl/llsc_datapath.sv
module llsc_datapath
  import llsc_pkg::*;
#(
  parameter int PADDR_W    = 32,
  parameter int DATA_W     = 64,
  parameter int LINK_SHIFT = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  llscStrobes_t                strobes,
  input  logic [PADDR_W-1:0]          llAddr,
  input  logic [PADDR_W-1:0]          scAddr,
  input  logic [DATA_W-1:0]           scData,
  input  logic                        scIsDouble,
  output logic                        memWrEn,
  output logic [PADDR_W-1:0]          memWrAddr,
  output logic [DATA_W-1:0]           memWrData,
  output logic                        memWrDouble,
  output logic [DATA_W-1:0]           scResult,
  output logic                        scResultValid,
  output logic                        addrErrStore,
  output logic [PADDR_W-LINK_SHIFT-1:0] linkAddr
);
  localparam int LINK_W = PADDR_W - LINK_SHIFT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWrEn       <= 1'b0;
      scResultValid <= 1'b0;
      addrErrStore  <= 1'b0;
      scResult      <= '0;
      memWrAddr     <= '0;
      memWrData     <= '0;
      memWrDouble   <= 1'b0;
      linkAddr      <= '0;
    end else begin
      memWrEn       <= strobes.wrEn;
      scResultValid <= strobes.resultValid;
      addrErrStore  <= strobes.addrErr;
      scResult      <= strobes.resultValid ? DATA_W'(strobes.resultBit) : '0;
      if (strobes.wrEn) begin
        memWrAddr   <= scAddr;
        memWrData   <= scData;
        memWrDouble <= scIsDouble;
      end
      if (strobes.llCapture) linkAddr <= llAddr[PADDR_W-1:LINK_SHIFT];
    end
  end

  AST_WR_MEANS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> scResultValid && scResult == DATA_W'(1)); // R4
  AST_RESULT_BINARY: assert property (@(posedge clk) disable iff (!rstN)
    scResult[DATA_W-1:1] == '0); // R5
  AST_NO_WR_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    addrErrStore |-> !memWrEn && !scResultValid); // R7
  AST_LINK_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.llCapture |=> linkAddr == $past(llAddr[PADDR_W-1:LINK_SHIFT])); // R3
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn && !strobes.wrEn |=> !memWrEn); // R4
  initial assert (LINK_W > 0); // R3
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int PADDR_W    = 32,
  parameter int DATA_W     = 64,
  parameter int LINK_SHIFT = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          llValid,
  input  logic [PADDR_W-1:0]            llAddr,
  input  logic                          scValid,
  input  logic                          scIsDouble,
  input  logic [PADDR_W-1:0]            scAddr,
  input  logic [DATA_W-1:0]             scData,
  input  logic                          eretClr,
  output logic                          memWrEn,
  output logic [PADDR_W-1:0]            memWrAddr,
  output logic [DATA_W-1:0]             memWrData,
  output logic                          memWrDouble,
  output logic [DATA_W-1:0]             scResult,
  output logic                          scResultValid,
  output logic                          addrErrStore,
  output logic [PADDR_W-LINK_SHIFT-1:0] linkAddr,
  output logic                          linkBit
);
  localparam int DOUBLE_BYTES = DATA_W / 8;
  localparam int WORD_BYTES   = DOUBLE_BYTES / 2;
  localparam int LOW_W        = $clog2(DOUBLE_BYTES);

  llscStrobes_t strobes;

  llsc_ctrl #(
    .WORD_BYTES  (WORD_BYTES),
    .DOUBLE_BYTES(DOUBLE_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .llValid   (llValid),
    .scValid   (scValid),
    .scIsDouble(scIsDouble),
    .scAddrLow (scAddr[LOW_W-1:0]),
    .eretClr   (eretClr),
    .strobes   (strobes),
    .linkBit   (linkBit)
  );

  llsc_datapath #(
    .PADDR_W   (PADDR_W),
    .DATA_W    (DATA_W),
    .LINK_SHIFT(LINK_SHIFT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .llAddr       (llAddr),
    .scAddr       (scAddr),
    .scData       (scData),
    .scIsDouble   (scIsDouble),
    .memWrEn      (memWrEn),
    .memWrAddr    (memWrAddr),
    .memWrData    (memWrData),
    .memWrDouble  (memWrDouble),
    .scResult     (scResult),
    .scResultValid(scResultValid),
    .addrErrStore (addrErrStore),
    .linkAddr     (linkAddr)
  );
endmodule

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        llValid, scValid, scIsDouble, eretClr;
  logic [31:0] llAddr, scAddr;
  logic [63:0] scData;
  logic        memWrEn, memWrDouble, scResultValid, addrErrStore, linkBit;
  logic [31:0] memWrAddr;
  logic [63:0] memWrData, scResult;
  logic [27:0] linkAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  llsc_monitor u_dut (
    .clk(clk), .rstN(rstN), .llValid(llValid), .llAddr(llAddr),
    .scValid(scValid), .scIsDouble(scIsDouble), .scAddr(scAddr),
    .scData(scData), .eretClr(eretClr), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .memWrDouble(memWrDouble),
    .scResult(scResult), .scResultValid(scResultValid),
    .addrErrStore(addrErrStore), .linkAddr(linkAddr), .linkBit(linkBit)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    llValid = 0; scValid = 0; eretClr = 0; scIsDouble = 0;
  endtask

  task automatic setLink(input bit v);
    idle();
    if (v) begin llValid = 1; llAddr = 32'h1234_5670; end
    else eretClr = 1;
    tick();
    idle();
  endtask

  initial begin
    idle(); llAddr = 0; scAddr = 0; scData = 0;
    rstN = 0;
    tick(); tick();
    chk("R1 linkBit", linkBit, 0);
    chk("R1 memWrEn", memWrEn, 0);
    chk("R1 resultValid", scResultValid, 0);
    chk("R1 scResult", scResult, 0);
    chk("R1 addrErr", addrErrStore, 0);
    chk("R1 linkAddr", linkAddr, 0);
    rstN = 1;
    tick();

    // R2 R3: link-address capture over several addresses
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a;
      a = 32'h9E37_79B9 * (i + 1);
      setLink(0);
      llValid = 1; llAddr = a;
      tick(); idle();
      chk("R2 armed", linkBit, 1);
      chk("R3 linkAddr", linkAddr, 64'(a >> 4));
    end

    // Sweep: prior flag x size x low address bits (R4..R8)
    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d < 2; d++) begin
        for (int lo = 0; lo < 8; lo++) begin
          bit mis;
          logic [31:0] a;
          logic [63:0] dat;
          mis = d ? (lo != 0) : ((lo & 3) != 0);
          a   = 32'h0040_1000 + 32'(lo) + 32'(p * 64 + d * 16);
          dat = 64'hA5A5_0000_0000_0000 | 64'(p * 100 + d * 10 + lo);
          setLink(p[0]);
          scValid = 1; scIsDouble = d[0]; scAddr = a; scData = dat;
          tick(); idle();
          chk("R7 addrErr", addrErrStore, 64'(mis));
          chk("R4 memWrEn", memWrEn, 64'(!mis && p == 1));
          chk("R5 resultValid", scResultValid, 64'(!mis));
          if (!mis) chk("R5 scResult", scResult, 64'(p));
          if (!mis && p == 1) begin
            chk("R4 wrAddr", memWrAddr, 64'(a));
            chk("R4 wrData", memWrData, dat);
            chk("R4 wrDouble", memWrDouble, 64'(d));
          end
          if (mis) chk("R8 link kept", linkBit, 64'(p));
          else     chk("R6 link cleared", linkBit, 0);
          tick();
          chk("R4 pulse ends", memWrEn, 0);
        end
      end
    end

    // R9: exception return clears an armed reservation
    setLink(1);
    eretClr = 1; tick(); idle();
    chk("R9 eret clears", linkBit, 0);

    // R10: eret and LL together
    setLink(1);
    eretClr = 1; llValid = 1; llAddr = 32'hCAFE_BAB0;
    tick(); idle();
    chk("R10 eret wins", linkBit, 0);
    chk("R3 addr on collision", linkAddr, 64'(32'hCAFE_BAB0 >> 4));

    // R11: LL and aligned SC together, prior 0 then prior 1
    for (int p = 0; p < 2; p++) begin
      setLink(p[0]);
      llValid = 1; llAddr = 32'h0000_0100;
      scValid = 1; scIsDouble = 1; scAddr = 32'h0000_0200; scData = 64'h1;
      tick(); idle();
      chk("R11 result from prior flag", scResult, 64'(p));
      chk("R11 write from prior flag", memWrEn, 64'(p));
      chk("R11 link ends set", linkBit, 1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule